// File: doc/BRIEF.md
# Paired-Channel Compare Toggle Unit

This block watches a 16-bit free-running count that arrives from a timer outside the block. It has four compare channels, and each channel holds a 16-bit compare value. When the count advances onto a channel's value, that channel raises its event flag. If the channel's pin driver is enabled, the channel also inverts the level of its output pin. Only a change of the count can produce an event. A count that stalls on a matching value produces nothing more.

The channels work in two pairs, channels 0/1 and channels 2/3. Each pair has one control word. That word holds, for each channel of the pair, an event flag, an interrupt enable and a pin enable. It also holds one linking bit. When the linking bit is set, the pair's second pin inverts on a match of either channel in the pair. Each pair drives its own interrupt line. Software loads compare values and control words over a simple single-cycle register bus. Compare values are always written as whole 16-bit words.

Top module: `compare_toggle_unit`

## Requirements
- R1: Addresses 0 to 3 hold the compare values of channels 0 to 3. A write stores all 16 bits, and a read returns the stored word. After reset each compare value reads 0xFFFF. Reads of addresses 6 and 7 return 0.
- R2: Address 4 is the control word of pair 0 (channels 0/1), and address 5 is the control word of pair 1 (channels 2/3). Bits [1:0] are the event flags of the first and second channel, bits [3:2] the interrupt enables, bits [5:4] the pin enables, and bit 6 the linking bit. Bits [15:7] read 0.
- R3: A channel's match occurs at a clock edge where the count differs from its value at the previous edge and equals that channel's stored compare value. A match sets the channel's event flag at that edge.
- R4: On its own match, a channel with its pin enable set inverts its output pin at that edge. With the pin enable clear, the pin does not change.
- R5: When a pair's linking bit is 1, the pair's second pin (channel 1 or 3) inverts on a match of either channel in the pair. If both channels match at the same edge, that pin inverts only once. The first pin of a pair responds only to its own match.
- R6: While the count holds the same value, no match occurs, however many cycles pass. The first edge after reset produces no match.
- R7: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. If a match and a clearing write reach the same flag at the same edge, the flag ends up set.
- R8: The interrupt line of pair p is high exactly while some channel of that pair has both its flag and its interrupt enable set.
- R9: All output pins are 0 after reset. Loading a compare value never inverts a pin by itself, even when the loaded value equals a stalled count.
- R10: After reset all flags, enables and linking bits are 0, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerCount | input | 16 | Free-running count from the external timer |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| outPin | output | 4 | Output pin level of each channel |
| irq | output | 2 | Interrupt request of each pair |

## Verification
Two events can land on the same flag at the same edge: a match setting it and a control write that clears it. The bench forces this case directly. It advances the count onto a compare value in the same cycle that it writes a 0 to that flag, and it expects the flag and the interrupt line to stay high. A second kind of collision, both channels of a linked pair matching together, is also set up directly, and the shared pin must invert exactly once. The random phase keeps compare values close to the running count, so both kinds of collision keep recurring. Every cycle is judged against a reference model kept in the bench.

// File: rtl/oct_pkg.sv
package oct_pkg;

  // Bit positions inside a pair control word
  localparam int FLAG_LSB = 0;
  localparam int IE_LSB   = 2;
  localparam int OE_LSB   = 4;
  localparam int LINK_POS = 6;

  // Per-channel strobes and settings from control to datapath
  typedef struct packed {
    logic load;          // store bus write data into the compare value
    logic pinEn;         // output pin may invert
    logic partnerToggle; // also invert on the partner channel's match
  } chanCtl_t;

endpackage

// File: rtl/oct_datapath.sv
module oct_datapath
  import oct_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int CNT_W     = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [CNT_W-1:0]                  timerCount,
  input  chanCtl_t [2*NUM_PAIRS-1:0]        ctl,
  input  logic [CNT_W-1:0]                  wrData,
  output logic [2*NUM_PAIRS-1:0][CNT_W-1:0] cmpVal,
  output logic [2*NUM_PAIRS-1:0]            matchEv,
  output logic [2*NUM_PAIRS-1:0]            outPin
);

  localparam int NCH = 2 * NUM_PAIRS;

  logic [CNT_W-1:0] prevCount;
  logic             advance;
  logic [NCH-1:0]   toggleHit;

  // Count seen at the previous edge; tracked through reset, so the
  // first edge after reset sees no change.
  always_ff @(posedge clk) begin
    prevCount <= timerCount;
  end

  assign advance = (timerCount != prevCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal <= '1;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (ctl[i].load) cmpVal[i] <= wrData;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic partnerHit;

    assign matchEv[i] = advance && (timerCount == cmpVal[i]);

    if (i % 2 == 1) begin : g_second
      assign partnerHit = matchEv[i-1] && ctl[i].partnerToggle;
    end else begin : g_first
      assign partnerHit = 1'b0;
    end

    assign toggleHit[i] = ctl[i].pinEn && (matchEv[i] || partnerHit);

    // R4: a pin only moves when its pin enable was set
    p_toggle_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
      (outPin[i] != $past(outPin[i])) |-> $past(ctl[i].pinEn));

    // R6: a held count leaves the pin unchanged
    p_stall_no_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
      $stable(timerCount) |=> $stable(outPin[i]));

    // R9: loading a compare value under a held count does not move the pin
    p_load_no_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[i].load && (timerCount == prevCount)) |=> $stable(outPin[i]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPin <= '0;
    end else begin
      outPin <= outPin ^ toggleHit;
    end
  end

endmodule

// File: rtl/oct_control.sv
module oct_control
  import oct_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWe,
  input  logic [ADDR_W-1:0]                 busAddr,
  input  logic [CNT_W-1:0]                  busWdata,
  input  logic [2*NUM_PAIRS-1:0][CNT_W-1:0] cmpVal,
  input  logic [2*NUM_PAIRS-1:0]            matchEv,
  output chanCtl_t [2*NUM_PAIRS-1:0]        ctl,
  output logic [CNT_W-1:0]                  rdData,
  output logic [NUM_PAIRS-1:0]              irq
);

  localparam int NCH = 2 * NUM_PAIRS;

  logic [NCH-1:0]       flagReg;
  logic [NCH-1:0]       ieReg;
  logic [NCH-1:0]       oeReg;
  logic [NUM_PAIRS-1:0] linkReg;
  logic [NUM_PAIRS-1:0] ctrlSel;

  always_comb begin
    for (int p = 0; p < NUM_PAIRS; p++) begin
      ctrlSel[p] = busWe && (busAddr == ADDR_W'(NCH + p));
    end
    for (int i = 0; i < NCH; i++) begin
      ctl[i].load          = busWe && (busAddr == ADDR_W'(i));
      ctl[i].pinEn         = oeReg[i];
      ctl[i].partnerToggle = (i % 2 == 1) && linkReg[i/2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
      ieReg   <= '0;
      oeReg   <= '0;
      linkReg <= '0;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (ctrlSel[p]) begin
          ieReg[2*p +: 2] <= busWdata[IE_LSB +: 2];
          oeReg[2*p +: 2] <= busWdata[OE_LSB +: 2];
          linkReg[p]      <= busWdata[LINK_POS];
        end
      end
      // Clearing write first, then a match sets: the match wins a tie
      for (int i = 0; i < NCH; i++) begin
        flagReg[i] <= (flagReg[i] & ~(ctrlSel[i/2] & ~busWdata[FLAG_LSB + (i % 2)]))
                      | matchEv[i];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PAIRS; p++) begin
      irq[p] = |(flagReg[2*p +: 2] & ieReg[2*p +: 2]);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NCH; i++) begin
      if (busAddr == ADDR_W'(i)) rdData = cmpVal[i];
    end
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (busAddr == ADDR_W'(NCH + p)) begin
        rdData[FLAG_LSB +: 2] = flagReg[2*p +: 2];
        rdData[IE_LSB +: 2]   = ieReg[2*p +: 2];
        rdData[OE_LSB +: 2]   = oeReg[2*p +: 2];
        rdData[LINK_POS]      = linkReg[p];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_flagChk
    // R3: a match leaves the flag set
    p_match_sets_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
      matchEv[i] |=> flagReg[i]);

    // R7: a zero written to a flag with no match clears it
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlSel[i/2] && !busWdata[FLAG_LSB + (i % 2)] && !matchEv[i]) |=> !flagReg[i]);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_irqChk
    // R8: a request only rises after a bus write or a match of its pair
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[p]) |-> ($past(busWe) || $past(|matchEv[2*p +: 2])));
  end

endmodule

// File: rtl/compare_toggle_unit.sv
module compare_toggle_unit
  import oct_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         timerCount,
  input  logic                     busWe,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [CNT_W-1:0]         busWdata,
  output logic [CNT_W-1:0]         busRdata,
  output logic [2*NUM_PAIRS-1:0]   outPin,
  output logic [NUM_PAIRS-1:0]     irq
);

  localparam int NCH = 2 * NUM_PAIRS;

  chanCtl_t [NCH-1:0]        chanCtl;
  logic [NCH-1:0][CNT_W-1:0] cmpVal;
  logic [NCH-1:0]            matchEv;

  oct_control #(
    .NUM_PAIRS(NUM_PAIRS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .cmpVal  (cmpVal),
    .matchEv (matchEv),
    .ctl     (chanCtl),
    .rdData  (busRdata),
    .irq     (irq)
  );

  oct_datapath #(
    .NUM_PAIRS(NUM_PAIRS),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .timerCount(timerCount),
    .ctl       (chanCtl),
    .wrData    (busWdata),
    .cmpVal    (cmpVal),
    .matchEv   (matchEv),
    .outPin    (outPin)
  );

endmodule

// File: tb/test_compare_toggle_unit.sv
`timescale 1ns/1ps
module test_compare_toggle_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tc = 16'h0000;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'h0000;
  logic [15:0] busRdata;
  logic [3:0]  outPin;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [15:0] mCmp [4];
  bit   [3:0]  mFlag, mIe, mOe, mOut;
  bit   [1:0]  mLink;
  logic [15:0] mPrev;

  always #2.5 clk = ~clk;

  compare_toggle_unit i_compare_toggle_unit (
    .clk(clk), .rstN(rstN), .timerCount(tc), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .outPin(outPin), .irq(irq)
  );

  function automatic logic [15:0] expRd(int a);
    logic [15:0] r = '0;
    if (a < 4) r = mCmp[a];
    else if (a < 6) begin
      int p = a - 4;
      r[1:0] = mFlag[2*p +: 2];
      r[3:2] = mIe[2*p +: 2];
      r[5:4] = mOe[2*p +: 2];
      r[6]   = mLink[p];
    end
    return r;
  endfunction

  function automatic logic [1:0] expIrq();
    logic [1:0] r;
    for (int p = 0; p < 2; p++) r[p] = |(mFlag[2*p +: 2] & mIe[2*p +: 2]);
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, step the model, sample at the next falling edge
  task automatic cycle(logic [15:0] t, bit we, int a, logic [15:0] d, string tag);
    bit [3:0] match;
    bit       tick;
    tc = t; busWe = we; busAddr = 3'(a); busWdata = d;
    tick = (t != mPrev);
    for (int i = 0; i < 4; i++) match[i] = tick && (t == mCmp[i]);
    for (int i = 0; i < 4; i++) begin
      bit hit = match[i] || ((i % 2 == 1) && mLink[i/2] && match[i-1]);
      if (mOe[i] && hit) mOut[i] = ~mOut[i];
    end
    if (we) begin
      if (a < 4) mCmp[a] = d;
      else if (a < 6) begin
        int p = a - 4;
        mFlag[2*p]   = mFlag[2*p] & d[0];
        mFlag[2*p+1] = mFlag[2*p+1] & d[1];
        mIe[2*p +: 2] = d[3:2];
        mOe[2*p +: 2] = d[5:4];
        mLink[p] = d[6];
      end
    end
    mFlag = mFlag | match;
    mPrev = t;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
    check({tag, " outPin"}, {12'b0, outPin}, {12'b0, mOut});
    check({tag, " irq R8"}, {14'b0, irq}, {14'b0, expIrq()});
  endtask

  task automatic readChk(int a, string tag);
    busWe = 1'b0; busAddr = 3'(a);
    #1;
    check(tag, busRdata, expRd(a));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) mCmp[i] = 16'hFFFF;
    mFlag = '0; mIe = '0; mOe = '0; mOut = '0; mLink = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    mPrev = tc;

    // R9 R10: reset state
    check("R9 reset outPin", {12'b0, outPin}, 16'h0);
    check("R10 reset irq", {14'b0, irq}, 16'h0);
    readChk(4, "R10 reset ctrl0");
    readChk(5, "R10 reset ctrl1");
    readChk(0, "R1 reset cmp0");
    readChk(6, "R1 unused addr");

    // R1: compare loads
    cycle(16'h0000, 1, 0, 16'h0010, "R1 load0");
    cycle(16'h0000, 1, 1, 16'h0020, "R1 load1");
    cycle(16'h0000, 1, 2, 16'h0030, "R1 load2");
    cycle(16'h0000, 1, 3, 16'hA5C3, "R1 load3");
    readChk(2, "R1 cmp2");
    readChk(3, "R1 cmp3");

    // R2: pair 0 ctrl, pin and irq enable on channel 0
    cycle(16'h0000, 1, 4, 16'h0014, "R2 ctrl0");
    readChk(4, "R2 ctrl0 read");

    // R3 R4: advance onto channel 0 value
    cycle(16'h000F, 0, 0, 0, "R4 pre");
    cycle(16'h0010, 0, 0, 0, "R3 R4 match0");
    readChk(4, "R3 flag0 set");

    // R6: stalled count
    for (int k = 0; k < 5; k++) cycle(16'h0010, 0, 0, 0, "R6 stall");

    // R9: load equal to stalled count
    cycle(16'h0010, 1, 1, 16'h0010, "R9 load equal");
    readChk(4, "R9 no flag1");

    // R7: write 1 keeps, write 0 clears
    cycle(16'h0010, 1, 4, 16'h0017, "R7 write one");
    readChk(4, "R7 flag kept");
    cycle(16'h0010, 1, 4, 16'h0014, "R7 write zero");
    readChk(4, "R7 flag cleared");

    // R5: linked pair 0
    cycle(16'h0010, 1, 4, 16'h0070, "R5 link on");
    cycle(16'h0010, 1, 0, 16'h0040, "R5 load0");
    cycle(16'h0010, 1, 1, 16'h0050, "R5 load1");
    cycle(16'h0040, 0, 0, 0, "R5 partner match");
    cycle(16'h0050, 0, 0, 0, "R5 own match");

    // R7: clear and match on the same edge
    cycle(16'h0050, 1, 5, 16'h0004, "R7 ie2");
    cycle(16'h0030, 1, 5, 16'h0004, "R7 clear vs match");
    readChk(5, "R7 match wins");

    // R5: both channels of linked pair 1 match together
    cycle(16'h0030, 1, 2, 16'h0070, "R5 load2");
    cycle(16'h0030, 1, 3, 16'h0070, "R5 load3");
    cycle(16'h0030, 1, 5, 16'h0070, "R5 link1");
    cycle(16'h0070, 0, 0, 0, "R5 double match");

    // R4: pin enable off
    cycle(16'h0070, 1, 5, 16'h0020, "R4 oe2 off");
    cycle(16'h0080, 1, 2, 16'h0081, "R4 load2");
    cycle(16'h0081, 0, 0, 0, "R4 disabled pin");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] t = tc;
      int r = $urandom % 100;
      if (r < 60) t = tc + 16'd1;
      else if (r < 65) t = tc + 16'($urandom % 5);
      if ($urandom % 100 < 25) begin
        int a = $urandom % 6;
        logic [15:0] d = (a < 4) ? 16'(t + 16'($urandom % 6)) : 16'($urandom % 128);
        cycle(t, 1, a, d, "R3 R4 R5 R6 R7 random");
      end else begin
        cycle(t, 0, 0, 0, "R3 R4 R5 R6 random");
      end
      if (n % 16 == 0) readChk($urandom % 8, "R1 R2 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule